// File: doc/BRIEF.md
# Two-input pixel blend and raster-operation stage

This stage merges a destination pixel with a source pixel and emits one result pixel for each pair. A pixel is four 8-bit channels packed into 32 bits, with alpha in the top byte, so ARGB and AYUV data pass through the same path. A control word chooses the operating mode. In raster-operation mode, two independent 4-bit codes apply a bitwise logic function of source and destination. One code acts on the three colour channels and the other acts on the alpha channel. In blend mode, every channel is a rounded, saturated weighted sum of destination and source. Each of the two weights is picked by its own selector, with separate selectors for the colour channels and for alpha.

Configuration is plain. When `cfg_load` is high at a rising clock edge, both configuration words are captured. Each pixel is processed with the configuration that is in force on the edge where the pixel is accepted. Pixel pairs enter through a valid/ready interface and results leave through a second valid/ready interface. An input pair is accepted on an edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged. The stage then fills its two internal registers and drops `in_ready`. No pixel is lost or reordered.

Top module: `pix_blend_rop_stage`

## Requirements
- R1: The channel layout is alpha in [31:24], R/Cr in [23:16], G/Y in [15:8] and B/Cb in [7:0]. Colour settings act on the lower three bytes and alpha settings act on the top byte.
- R2: When control bit 31 is 0, the stage is in raster-operation mode. The colour code in control bits [7:4] and the alpha code in control bits [3:0] apply bitwise, with S = source and D = destination. The codes are: 0 D, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 all zeros, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D), 15 all ones.
- R3: Code 0 returns the destination channel unchanged for every possible source value.
- R4: When control bit 31 is 1, the stage is in blend mode. Each channel is min(255, (D·X + S·Y + 127) / 255), using integer division.
- R5: Weight selector codes are: 0 destination alpha, 1 255 minus destination alpha, 2 source alpha, 3 255 minus source alpha, 4 the fixed coefficient of that term. Codes 5, 6 and 7 give a weight of 0.
- R6: The blend word holds the fields below. Bits 31 and 23 are ignored.
  - colour X selector in [30:28] and colour Y selector in [26:24];
  - alpha X selector in [22:20] and alpha Y selector in [18:16];
  - coefficient X in [15:8] and coefficient Y in [7:0].
- R7: With `out_ready` held high, a pair accepted on edge k is delivered on the output handshake at edge k+2.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` stays stable. Every accepted pair produces exactly one result, in acceptance order.
- R9: A configuration loaded on edge k applies to pairs accepted after edge k. A pair accepted on edge k itself, or before it, uses the previous configuration.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, and the configuration selects raster-operation mode with both codes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Captures both configuration words |
| cfg_ctrl | input | 32 | Mode bit and raster-operation codes |
| cfg_blend | input | 32 | Weight selectors and fixed coefficients |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Stage can accept a pair |
| in_dst | input | 32 | Destination pixel |
| in_src | input | 32 | Source pixel |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pix | output | 32 | Result pixel |

## Verification
The embedded properties check these behaviours on every clock:
- a stalled result holds steady, and `out_valid` never drops without a handshake;
- the output is idle as reset is released;
- a colour code of 0 passes the destination through;
- every blended channel equals the rounded quotient of the registered sum, or the saturated maximum.

The bench's scenarios are needed for the rest:
- the value of each of the sixteen codes;
- each weight selector, including the codes that give zero weight;
- the fixed two-edge latency;
- the exact moment a configuration change takes effect;
- loss-free ordering under random back-pressure.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  // Field positions inside the two configuration words
  localparam int CW_MODE_BIT = 31;
  localparam int CW_CROP_LSB = 4;
  localparam int CW_AROP_LSB = 0;
  localparam int BW_CX_LSB   = 28;
  localparam int BW_CY_LSB   = 24;
  localparam int BW_AX_LSB   = 20;
  localparam int BW_AY_LSB   = 16;
  localparam int BW_KX_LSB   = 8;
  localparam int BW_KY_LSB   = 0;

  typedef enum logic [2:0] {
    W_DST_A     = 3'd0,
    W_INV_DST_A = 3'd1,
    W_SRC_A     = 3'd2,
    W_INV_SRC_A = 3'd3,
    W_COEF      = 3'd4
  } wsel_e;

  typedef enum logic [3:0] {
    ROP_KEEP_D   = 4'd0,
    ROP_S_AND_D  = 4'd1,
    ROP_S_AND_ND = 4'd2,
    ROP_S        = 4'd3,
    ROP_NS_AND_D = 4'd4,
    ROP_ZERO     = 4'd5,
    ROP_S_XOR_D  = 4'd6,
    ROP_S_OR_D   = 4'd7,
    ROP_NOR      = 4'd8,
    ROP_XNOR     = 4'd9,
    ROP_ND       = 4'd10,
    ROP_S_OR_ND  = 4'd11,
    ROP_NS       = 4'd12,
    ROP_NS_OR_D  = 4'd13,
    ROP_NAND     = 4'd14,
    ROP_ONES     = 4'd15
  } rop_e;
endpackage

// File: rtl/pbr_rop.sv
module pbr_rop
  import pbr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] s,
  input  logic [W-1:0] d,
  output logic [W-1:0] r
);
  always_comb begin
    unique case (rop_e'(code))
      ROP_KEEP_D:   r = d;
      ROP_S_AND_D:  r = s & d;
      ROP_S_AND_ND: r = s & ~d;
      ROP_S:        r = s;
      ROP_NS_AND_D: r = ~s & d;
      ROP_ZERO:     r = '0;
      ROP_S_XOR_D:  r = s ^ d;
      ROP_S_OR_D:   r = s | d;
      ROP_NOR:      r = ~(s | d);
      ROP_XNOR:     r = ~(s ^ d);
      ROP_ND:       r = ~d;
      ROP_S_OR_ND:  r = s | ~d;
      ROP_NS:       r = ~s;
      ROP_NS_OR_D:  r = ~s | d;
      ROP_NAND:     r = ~(s & d);
      ROP_ONES:     r = '1;
      default:      r = d;
    endcase
  end
endmodule

// File: rtl/pbr_wsel.sv
module pbr_wsel
  import pbr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [2:0]    code,
  input  logic [CW-1:0] dst_a,
  input  logic [CW-1:0] src_a,
  input  logic [CW-1:0] coef,
  output logic [CW-1:0] weight
);
  localparam logic [CW-1:0] MAXV = '1;

  always_comb begin
    case (wsel_e'(code))
      W_DST_A:     weight = dst_a;
      W_INV_DST_A: weight = MAXV - dst_a;
      W_SRC_A:     weight = src_a;
      W_INV_SRC_A: weight = MAXV - src_a;
      W_COEF:      weight = coef;
      default:     weight = '0;
    endcase
  end
endmodule

// File: rtl/pbr_mac.sv
module pbr_mac #(
  parameter int CW = 8,
  parameter int SW = 2 * CW + 1
) (
  input  logic [CW-1:0] d,
  input  logic [CW-1:0] s,
  input  logic [CW-1:0] wx,
  input  logic [CW-1:0] wy,
  output logic [SW-1:0] sum
);
  logic [2*CW-1:0] px;
  logic [2*CW-1:0] py;

  always_comb begin
    px  = {{CW{1'b0}}, d} * {{CW{1'b0}}, wx};
    py  = {{CW{1'b0}}, s} * {{CW{1'b0}}, wy};
    sum = {1'b0, px} + {1'b0, py};
  end
endmodule

// File: rtl/pbr_norm.sv
module pbr_norm #(
  parameter int CW = 8,
  parameter int SW = 2 * CW + 1
) (
  input  logic [SW-1:0] sum,
  output logic [CW-1:0] res
);
  localparam int          MAXI = (1 << CW) - 1;
  localparam logic [SW-1:0] DIV  = SW'(MAXI);
  localparam logic [SW-1:0] HALF = SW'(MAXI / 2);

  logic [SW-1:0] rounded;
  logic [SW-1:0] quot;

  always_comb begin
    rounded = sum + HALF;
    quot    = rounded / DIV;
    res     = (quot > DIV) ? '1 : quot[CW-1:0];
  end
endmodule

// File: rtl/pix_blend_rop_stage.sv
module pix_blend_rop_stage #(
  parameter int CH_W  = 8,
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [31:0]             cfg_ctrl,
  input  logic [31:0]             cfg_blend,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CH_W*LANES-1:0]   in_dst,
  input  logic [CH_W*LANES-1:0]   in_src,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CH_W*LANES-1:0]   out_pix
);
  import pbr_pkg::*;

  localparam int PIX_W = CH_W * LANES;
  localparam int COL_W = PIX_W - CH_W;
  localparam int SUM_W = 2 * CH_W + 1;
  localparam int AL    = LANES - 1;
  localparam int MAXI  = (1 << CH_W) - 1;
  localparam int HALFI = MAXI / 2;

  // Configuration registers (only meaningful fields are kept)
  logic            mode_q;
  logic [3:0]      crop_q, arop_q;
  logic [2:0]      cx_q, cy_q, ax_q, ay_q;
  logic [CH_W-1:0] kx_q, ky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      crop_q <= '0;
      arop_q <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
      ax_q   <= '0;
      ay_q   <= '0;
      kx_q   <= '0;
      ky_q   <= '0;
    end else if (cfg_load) begin
      mode_q <= cfg_ctrl[CW_MODE_BIT];
      crop_q <= cfg_ctrl[CW_CROP_LSB +: 4];
      arop_q <= cfg_ctrl[CW_AROP_LSB +: 4];
      cx_q   <= cfg_blend[BW_CX_LSB +: 3];
      cy_q   <= cfg_blend[BW_CY_LSB +: 3];
      ax_q   <= cfg_blend[BW_AX_LSB +: 3];
      ay_q   <= cfg_blend[BW_AY_LSB +: 3];
      kx_q   <= cfg_blend[BW_KX_LSB +: CH_W];
      ky_q   <= cfg_blend[BW_KY_LSB +: CH_W];
    end
  end

  // Weight selection from the incoming alphas
  logic [CH_W-1:0] dst_a, src_a;
  logic [CH_W-1:0] w_cx, w_cy, w_ax, w_ay;

  assign dst_a = in_dst[PIX_W-1 -: CH_W];
  assign src_a = in_src[PIX_W-1 -: CH_W];

  pbr_wsel #(.CW(CH_W)) u_sel_cx (.code(cx_q), .dst_a(dst_a), .src_a(src_a), .coef(kx_q), .weight(w_cx));
  pbr_wsel #(.CW(CH_W)) u_sel_cy (.code(cy_q), .dst_a(dst_a), .src_a(src_a), .coef(ky_q), .weight(w_cy));
  pbr_wsel #(.CW(CH_W)) u_sel_ax (.code(ax_q), .dst_a(dst_a), .src_a(src_a), .coef(kx_q), .weight(w_ax));
  pbr_wsel #(.CW(CH_W)) u_sel_ay (.code(ay_q), .dst_a(dst_a), .src_a(src_a), .coef(ky_q), .weight(w_ay));

  // Pipeline state
  logic             v1, v2;
  logic             blend1;
  logic [PIX_W-1:0] rop1;
  logic [PIX_W-1:0] pix2;
  logic [SUM_W-1:0] sum_d [LANES];
  logic [SUM_W-1:0] sum1  [LANES];
  logic [PIX_W-1:0] rop_d;
  logic [PIX_W-1:0] norm_d;
  logic             rdy1, rdy2;

  assign rdy2      = !v2 || out_ready;
  assign rdy1      = !v1 || rdy2;
  assign in_ready  = rdy1;
  assign out_valid = v2;
  assign out_pix   = pix2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit IS_A = (l == AL);
    logic [CH_W-1:0] wx, wy;
    logic [3:0]      code;

    assign wx   = IS_A ? w_ax : w_cx;
    assign wy   = IS_A ? w_ay : w_cy;
    assign code = IS_A ? arop_q : crop_q;

    pbr_mac #(.CW(CH_W), .SW(SUM_W)) u_mac (
      .d  (in_dst[l*CH_W +: CH_W]),
      .s  (in_src[l*CH_W +: CH_W]),
      .wx (wx),
      .wy (wy),
      .sum(sum_d[l])
    );

    pbr_rop #(.W(CH_W)) u_rop (
      .code(code),
      .s   (in_src[l*CH_W +: CH_W]),
      .d   (in_dst[l*CH_W +: CH_W]),
      .r   (rop_d[l*CH_W +: CH_W])
    );

    pbr_norm #(.CW(CH_W), .SW(SUM_W)) u_norm (
      .sum(sum1[l]),
      .res(norm_d[l*CH_W +: CH_W])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sum1[l] <= '0;
      else if (in_valid && rdy1)     sum1[l] <= sum_d[l];
    end

    // R4: a blended channel is the rounded quotient of its sum, or saturated
    p_round_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v1 && rdy2 && blend1) |=>
        ((int'(out_pix[l*CH_W +: CH_W]) * MAXI <= int'($past(sum1[l])) + HALFI) &&
         ((int'(out_pix[l*CH_W +: CH_W]) == MAXI) ||
          ((int'(out_pix[l*CH_W +: CH_W]) + 1) * MAXI > int'($past(sum1[l])) + HALFI))));
  end

  // Stage 1: operands reduced to sums / logic results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      blend1 <= 1'b0;
      rop1   <= '0;
    end else if (rdy1) begin
      v1 <= in_valid;
      if (in_valid) begin
        blend1 <= mode_q;
        rop1   <= rop_d;
      end
    end
  end

  // Stage 2: normalised output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      pix2 <= '0;
    end else if (rdy2) begin
      v2 <= v1;
      if (v1) pix2 <= blend1 ? norm_d : rop1;
    end
  end

  // R8: a stalled result is held
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R8: a result only disappears after a handshake
  p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R10: output idle as reset is released
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R3: colour code 0 passes the destination colour through
  p_nop_passes_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode_q && crop_q == 4'd0) |=>
      (rop1[COL_W-1:0] == $past(in_dst[COL_W-1:0])));
endmodule

// File: tb/sim_pix_blend_rop_stage.sv
module sim_pix_blend_rop_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_ctrl = '0;
  logic [31:0] cfg_blend = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dst = '0;
  logic [31:0] in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pix;

  always #2 clk = ~clk;

  pix_blend_rop_stage u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
    .cfg_blend(cfg_blend), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    done    = 0;
  bit    lat_chk = 0;
  bit    bp_on   = 0;
  string cur_req = "R10";
  logic [31:0] m_ctrl = '0, m_blend = '0;
  logic [31:0] exp_q[$];
  int          acc_q[$];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_pix = '0;
  logic [31:0] e_pix;
  int          e_acc;
  logic [31:0] rng = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] next_rnd();
    rng = rng * 32'd1664525 + 32'd1013904223;
    return rng;
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, expv);
    end
  endtask

  function automatic int wgt(int code, int da, int sa, int k);
    case (code)
      0: return da;
      1: return 255 - da;
      2: return sa;
      3: return 255 - sa;
      4: return k;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] rop8(int code, logic [7:0] s, logic [7:0] d);
    case (code)
      0:  return d;
      1:  return s & d;
      2:  return s & ~d;
      3:  return s;
      4:  return ~s & d;
      5:  return 8'h00;
      6:  return s ^ d;
      7:  return s | d;
      8:  return ~(s | d);
      9:  return ~(s ^ d);
      10: return ~d;
      11: return s | ~d;
      12: return ~s;
      13: return ~s | d;
      14: return ~(s & d);
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] model(logic [31:0] c, logic [31:0] b,
                                        logic [31:0] dst, logic [31:0] src);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      int d, s, wx, wy, v;
      bit is_a;
      is_a = (l == 3);
      d = int'(dst[l*8 +: 8]);
      s = int'(src[l*8 +: 8]);
      if (c[31]) begin
        wx = wgt(int'(is_a ? b[22:20] : b[30:28]), int'(dst[31:24]), int'(src[31:24]), int'(b[15:8]));
        wy = wgt(int'(is_a ? b[18:16] : b[26:24]), int'(dst[31:24]), int'(src[31:24]), int'(b[7:0]));
        v = (d * wx + s * wy + 127) / 255;
        if (v > 255) v = 255;
        r[l*8 +: 8] = 8'(v);
      end else begin
        r[l*8 +: 8] = rop8(int'(is_a ? c[3:0] : c[7:4]), src[l*8 +: 8], dst[l*8 +: 8]);
      end
    end
    return r;
  endfunction

  // Reference model and comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "result with nothing pending", out_pix, 32'h0);
        else begin
          e_pix = exp_q.pop_front();
          e_acc = acc_q.pop_front();
          chk(out_pix == e_pix, "result pixel", out_pix, e_pix);
          if (lat_chk) chk(cyc - e_acc == 2, "R7 latency in edges", 32'(cyc - e_acc), 32'd2);
        end
      end
      if (prev_stall) chk(out_valid && out_pix == prev_pix, "R8 held during stall", out_pix, prev_pix);
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pix;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(m_ctrl, m_blend, in_dst, in_src));
        acc_q.push_back(cyc);
      end
      if (cfg_load) begin
        m_ctrl  = cfg_ctrl;
        m_blend = cfg_blend;
      end
    end
  end

  // Consumer back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bp_on) out_ready = next_rnd()[9];
      else       out_ready = 1'b1;
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load_cfg(logic [31:0] c, logic [31:0] b);
    cfg_ctrl = c; cfg_blend = b; cfg_load = 1'b1;
    tick(1);
    cfg_load = 1'b0;
  endtask

  task automatic send(logic [31:0] d, logic [31:0] s);
    bit acc;
    in_dst = d; in_src = s; in_valid = 1'b1;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    tick(n);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R10";
    chk(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'h1);
    @(posedge clk); #1;
    // R10: default configuration is code 0 on both lanes: output equals dst
    send(32'h1122_3344, 32'hFFEE_DDCC);
    idle(4);

    // R2: every raster code on colour, its mirror on alpha
    cur_req = "R2";
    for (int code = 0; code < 16; code++) begin
      load_cfg({24'h0, 4'(code), 4'(15 - code)}, 32'h0);
      send(32'hF0CC_AA55, 32'h3C0F_66FF);
      send(next_rnd(), next_rnd());
      send(next_rnd(), next_rnd());
      idle(3);
    end

    // R3: code 0 on both lanes ignores the source
    cur_req = "R3";
    load_cfg(32'h00AB_CD00, 32'h0);
    for (int i = 0; i < 5; i++) send(32'h5A69_C3E1, next_rnd());
    idle(4);

    // R1: lane positions, colour copy with alpha forced to ones
    cur_req = "R1";
    load_cfg(32'h0000_003F, 32'h0);
    send(32'h0102_0304, 32'h80A1_B2C3);
    send(32'h7F00_FF00, 32'h00FF_00FF);
    idle(4);

    // R4: default source-over blend
    cur_req = "R4";
    load_cfg(32'h8000_0000, 32'h3234_00FF);
    send(32'hFF20_4060, 32'h0080_A0C0);
    send(32'hFF20_4060, 32'hFF80_A0C0);
    send(32'h4010_2030, 32'h80F0_E0D0);
    send(32'h0000_0000, 32'h40FF_FFFF);
    // saturation with both coefficients at full scale
    load_cfg(32'h8000_0000, 32'h4444_FFFF);
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(32'h8080_8080, 32'h8181_8181);
    idle(4);

    // R6: reserved bits 31 and 23 set must not matter
    cur_req = "R6";
    load_cfg(32'h8000_0000, 32'hB2B4_00FF);
    send(32'hFF20_4060, 32'h8080_A0C0);
    send(32'h1234_5678, 32'hC0DE_F00D);
    idle(4);

    // R5: every selector code on every term, including zero-weight codes
    cur_req = "R5";
    for (int c = 0; c < 8; c++) begin
      load_cfg(32'h8000_0000, {1'b0, 3'(c), 1'b0, 3'(7 - c), 1'b0, 3'(c ^ 3), 1'b0, 3'(c + 1), 8'h5A, 8'hC3});
      send(32'h6633_99CC, 32'hA955_AA11);
      send(next_rnd(), next_rnd());
      idle(3);
    end

    // R7: fixed latency with no stall
    cur_req = "R7";
    load_cfg(32'h0000_0069, 32'h0);
    tick(2);
    lat_chk = 1;
    for (int i = 0; i < 4; i++) begin
      send(next_rnd(), next_rnd());
      idle(3);
    end
    send(next_rnd(), next_rnd());
    send(next_rnd(), next_rnd());
    idle(4);
    lat_chk = 0;

    // R9: configuration loaded on the same edge as a pixel
    cur_req = "R9";
    load_cfg(32'h0000_0033, 32'h0);
    send(32'h1111_1111, 32'h2222_2222);
    cfg_ctrl = 32'h8000_0000; cfg_blend = 32'h3234_00FF; cfg_load = 1'b1;
    send(32'h4444_4444, 32'h8888_8888);
    cfg_load = 1'b0;
    send(32'h4444_4444, 32'h8888_8888);
    idle(4);

    // R8: random back-pressure and input gaps, mixed modes
    cur_req = "R8";
    bp_on = 1;
    for (int i = 0; i < 90; i++) begin
      if (i % 15 == 0) begin
        in_valid = 1'b0;
        if ((i / 15) % 2 == 0) load_cfg({24'h0, next_rnd()[7:0]}, 32'h0);
        else load_cfg(32'h8000_0000, next_rnd() & 32'h7777_FFFF);
      end
      send(next_rnd(), next_rnd());
      if (next_rnd()[4]) idle(int'(next_rnd()[1:0]));
    end
    idle(2);
    bp_on = 0;
    idle(12);
    chk(exp_q.size() == 0, "R8 every accepted pair delivered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule